// File: doc/BRIEF.md
# PLL Setting Best-Fit Search Engine

This block works out a PLL control word for a requested output frequency. It takes two frequencies in hertz, the reference (parent) frequency and the target, and steps through every combination of three settings. The settings are a feedback multiplier, a divide-by-one-or-two stage ahead of the loop, and a power-of-two output divider. It keeps the combination whose output comes closest to the target without going above it. The winning fields are packed into one 32-bit control word. The word also carries a loop-filter range code, picked from the reference frequency after the first divide stage.

A caller presents both frequencies and pulses `start`. The engine tries one candidate per clock and stops early as soon as a candidate hits the target exactly. It then raises `done` for one cycle with the word and a `no_fit` flag. `no_fit` is set when every candidate lies above the target. The search needs no divider. Both dividers are powers of two, so each candidate's output is the product `parent × (mul+1)` shifted right by `div1 + div2`, which gives the rounded-down integer quotient.

The controller has three states. IDLE waits for `start` and loads the inputs (IDLE→SCAN on start). SCAN evaluates one candidate per cycle. It leaves to DONE on an exact match or after the last candidate (SCAN→DONE). DONE asserts `done` and always returns to IDLE on the next clock (DONE→IDLE).

Top module: `pll_best_fit`

## Requirements
- R1: The candidate output is floor(parent × (mul+1) / ((div1+1) × 2^div2)), with mul 0..255, div1 0..1 and div2 0..7. Candidates above the target are never chosen. The chosen candidate has the smallest target-minus-output error of all the candidates that do not exceed the target.
- R2: Candidates are visited with div1 from 1 down to 0 (outermost), then div2 from 7 down to 0, then mul from 0 up to 255 (innermost). A candidate replaces the kept one only when its error is strictly smaller, so among equal errors the first one visited wins.
- R3: A candidate equal to the target ends the search at once. When the very first candidate (div1=1, div2=7, mul=0) is exact, `done` is high in the second cycle after the cycle in which `start` was sampled.
- R4: If every candidate exceeds the target, `no_fit` is 1 and `pll_word` is 0 when `done` is high. Otherwise `no_fit` is 0.
- R5: In `pll_word`, the filter code occupies bits 31:24, mul bits 23:16, div1 bit 8 and div2 bits 2:0. All other bits are 0.
- R6: The filter code comes from F = floor(floor(parent/1000000)/(div1+1)) of the chosen div1. It is 7 if F≥166, 6 if F≥104, 5 if F≥65, 4 if F≥42, 3 if F≥26, 2 if F≥16, 1 if F≥10, and 0 otherwise.
- R7: `done` is high for exactly one cycle per search. `pll_word` and `no_fit` change only in the cycle in which `done` is high, and hold their values until the next completion. `busy` is high from the cycle after `start` is accepted until `done` falls.
- R8: A `start` that arrives while `busy` is high is ignored: the running search keeps its original inputs and produces a single `done`.
- R9: After reset, `busy`, `done`, `no_fit` are 0 and `pll_word` is 0.
- R10: A search that finds no exact match takes all 4096 candidates. `done` is high in the 4097th cycle after the cycle in which `start` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only when not busy) |
| parent_hz | input | 32 | Reference frequency in Hz |
| target_hz | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_word | output | 32 | Packed filter code and PLL fields |
| no_fit | output | 1 | No candidate at or below the target |

## Verification
The engine is checked against an independent model of the full ordered scan under several stimulus types:
- Reachable targets with no exact hit show that the smallest non-negative error wins and that equal errors go to the earliest candidate.
- Targets hit exactly by the first candidate show the early exit and its two-cycle latency.
- A target below the smallest reachable output separates the `no_fit` path from a normal result.
- Reference frequencies either side of several filter thresholds, with div1 of 1 and 0, check the filter code and the field positions.
- A second `start` during a running search checks that it is ignored.

// File: rtl/pll_bf_pkg.sv
package pll_bf_pkg;
    localparam int MUL_W   = 8;
    localparam int D2_W    = 3;
    localparam int FILT_W  = 8;
    localparam int WORD_W  = 32;
    localparam int MUL_MAX = (1 << MUL_W) - 1;
    localparam int D2_MAX  = (1 << D2_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } bf_state_e;

    // Field placement in the control word
    function automatic logic [WORD_W-1:0] pack_word(
        input logic [FILT_W-1:0] filt,
        input logic [MUL_W-1:0]  mul,
        input logic              d1,
        input logic [D2_W-1:0]   d2
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31:24] = filt;
        w[23:16] = mul;
        w[8]     = d1;
        w[2:0]   = d2;
        return w;
    endfunction
endpackage

// File: rtl/pll_bf_cand.sv
// Evaluates one candidate: output = (parent*(mul+1)) >> (d1+d2).
module pll_bf_cand
    import pll_bf_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] parent,
    input  logic [FREQ_W-1:0] target,
    input  logic [MUL_W-1:0]  mul,
    input  logic              d1,
    input  logic [D2_W-1:0]   d2,
    output logic              fits,
    output logic              exact,
    output logic [FREQ_W-1:0] err
);
    localparam int PROD_W = FREQ_W + MUL_W + 1;

    logic [MUL_W:0]    mplus;
    logic [D2_W:0]     shamt;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] tclk;
    logic [PROD_W-1:0] tgt_w;

    always_comb begin
        mplus = {1'b0, mul} + (MUL_W+1)'(1);
        shamt = {1'b0, d2} + (D2_W+1)'(d1);
        prod  = PROD_W'(parent) * PROD_W'(mplus);
        tclk  = prod >> shamt;
        tgt_w = PROD_W'(target);
        fits  = (tclk <= tgt_w);
        exact = (tclk == tgt_w);
        err   = target - tclk[FREQ_W-1:0];
    end
endmodule

// File: rtl/pll_bf_filt.sv
// Loop-filter range code from the pre-divided reference in MHz.
module pll_bf_filt
    import pll_bf_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] parent,
    input  logic              d1,
    output logic [FILT_W-1:0] code
);
    localparam int CW    = FREQ_W + 12;
    localparam int STEPS = 7;

    function automatic int step_mhz(input int i);
        case (i)
            0:       return 10;
            1:       return 16;
            2:       return 26;
            3:       return 42;
            4:       return 65;
            5:       return 104;
            default: return 166;
        endcase
    endfunction

    logic [CW-1:0] lim;

    always_comb begin
        code = '0;
        lim  = '0;
        for (int i = 0; i < STEPS; i++) begin
            lim = CW'(step_mhz(i)) * CW'(1000000);
            if (d1) lim = lim << 1;
            if (CW'(parent) >= lim) code = code + FILT_W'(1);
        end
    end
endmodule

// File: rtl/pll_best_fit.sv
module pll_best_fit
    import pll_bf_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] parent_hz,
    input  logic [FREQ_W-1:0] target_hz,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] pll_word,
    output logic              no_fit
);
    bf_state_e state, nstate;

    logic [FREQ_W-1:0] par_q, tgt_q;
    logic [MUL_W-1:0]  c_mul, b_mul, n_mul;
    logic              c_d1, b_d1, n_d1;
    logic [D2_W-1:0]   c_d2, b_d2, n_d2;
    logic [FREQ_W-1:0] b_err, n_err;
    logic              have_q, n_have;
    logic              c_fits, c_exact, take, last, fin;
    logic [FREQ_W-1:0] c_err;
    logic [FILT_W-1:0] filt;
    logic [WORD_W-1:0] word_q;
    logic              nofit_q;

    pll_bf_cand #(.FREQ_W(FREQ_W)) u_cand (
        .parent (par_q),
        .target (tgt_q),
        .mul    (c_mul),
        .d1     (c_d1),
        .d2     (c_d2),
        .fits   (c_fits),
        .exact  (c_exact),
        .err    (c_err)
    );

    pll_bf_filt #(.FREQ_W(FREQ_W)) u_filt (
        .parent (par_q),
        .d1     (n_d1),
        .code   (filt)
    );

    // Keep-best selection: strictly smaller error only (first of equals wins)
    always_comb begin
        take   = (state == ST_SCAN) && c_fits && (!have_q || (c_err < b_err));
        n_mul  = take ? c_mul : b_mul;
        n_d1   = take ? c_d1  : b_d1;
        n_d2   = take ? c_d2  : b_d2;
        n_err  = take ? c_err : b_err;
        n_have = have_q | take;
        last   = (c_d1 == 1'b0) && (c_d2 == '0) && (c_mul == MUL_W'(MUL_MAX));
        fin    = (state == ST_SCAN) && ((c_fits && c_exact) || last);
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_SCAN;
            ST_SCAN: if (fin)   nstate = ST_DONE;
            ST_DONE:            nstate = ST_IDLE;
            default:            nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Datapath: operands, scan counters, kept best, result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q   <= '0;
            tgt_q   <= '0;
            c_mul   <= '0;
            c_d1    <= 1'b1;
            c_d2    <= D2_W'(D2_MAX);
            b_mul   <= '0;
            b_d1    <= 1'b0;
            b_d2    <= '0;
            b_err   <= '0;
            have_q  <= 1'b0;
            word_q  <= '0;
            nofit_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                par_q  <= parent_hz;
                tgt_q  <= target_hz;
                c_mul  <= '0;
                c_d1   <= 1'b1;
                c_d2   <= D2_W'(D2_MAX);
                have_q <= 1'b0;
                b_err  <= '0;
            end else if (state == ST_SCAN) begin
                b_mul  <= n_mul;
                b_d1   <= n_d1;
                b_d2   <= n_d2;
                b_err  <= n_err;
                have_q <= n_have;
                if (c_mul == MUL_W'(MUL_MAX)) begin
                    c_mul <= '0;
                    if (c_d2 == '0) begin
                        c_d2 <= D2_W'(D2_MAX);
                        c_d1 <= 1'b0;
                    end else begin
                        c_d2 <= c_d2 - D2_W'(1);
                    end
                end else begin
                    c_mul <= c_mul + MUL_W'(1);
                end
                if (fin) begin
                    word_q  <= n_have ? pack_word(filt, n_mul, n_d1, n_d2) : '0;
                    nofit_q <= !n_have;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        pll_word = word_q;
        no_fit   = nofit_q;
    end

    // R7: completion pulse lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result changes only together with done
    a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(pll_word) && $stable(no_fit)) |-> done);

    // R8: start while busy leaves the latched operands alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(par_q) && $stable(tgt_q)));

    // R1: kept error never grows during a scan
    a_r1_err_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && $past(state == ST_SCAN) && $past(have_q))
            |-> (have_q && b_err <= $past(b_err)));

    // R4: no-fit result carries an all-zero word
    a_r4_nofit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        no_fit |-> (pll_word == '0));
endmodule

// File: tb/pll_best_fit_test.sv
`timescale 1ns/1ps
module pll_best_fit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] parent_hz = '0;
    logic [31:0] target_hz = '0;
    logic        busy, done, no_fit;
    logic [31:0] pll_word;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    pll_best_fit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .parent_hz(parent_hz), .target_hz(target_hz),
        .busy(busy), .done(done), .pll_word(pll_word), .no_fit(no_fit)
    );

    localparam int NVEC = 7;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'd24000000,   32'd600000000},
        {32'd27000000,   32'd123456789},
        {32'd100000000,  32'd7777777},
        {32'd300000000,  32'd1000000000},
        {32'd12000000,   32'd50000},
        {32'd50000000,   32'd333333},
        {32'd180000000,  32'd4000000000}
    };

    function automatic logic [31:0] filt_of(input longint p, input int d1);
        longint f;
        f = (p / 1000000) / (d1 + 1);
        if (f >= 166) return 7;
        if (f >= 104) return 6;
        if (f >= 65)  return 5;
        if (f >= 42)  return 4;
        if (f >= 26)  return 3;
        if (f >= 16)  return 2;
        if (f >= 10)  return 1;
        return 0;
    endfunction

    // Model of the ordered scan built from R1..R6
    task automatic model(input longint p, input longint t,
                         output logic [31:0] w, output bit nf);
        longint best = 0;
        bit have = 0;
        bit stop = 0;
        int bm = 0, b1 = 0, b2 = 0;
        for (int d1 = 1; d1 >= 0; d1--) begin
            for (int d2 = 7; d2 >= 0; d2--) begin
                for (int m = 0; m <= 255; m++) begin
                    longint tc;
                    tc = (p * (m + 1)) >>> (d1 + d2);
                    if (tc <= t) begin
                        if (!have || (t - tc) < best) begin
                            have = 1; best = t - tc; bm = m; b1 = d1; b2 = d2;
                        end
                        if (tc == t) stop = 1;
                    end
                    if (stop) break;
                end
                if (stop) break;
            end
            if (stop) break;
        end
        nf = !have;
        if (have) w = (filt_of(p, b1) << 24) | (32'(bm) << 16) | (32'(b1) << 8) | 32'(b2);
        else      w = 32'd0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] p, input logic [31:0] t,
                       output logic [31:0] w, output bit nf, output int lat);
        @(negedge clk);
        parent_hz = p; target_hz = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10000) begin
            @(negedge clk);
            lat++;
        end
        w = pll_word; nf = no_fit;
    endtask

    initial begin
        #(20ns * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w, ew;
        bit nf, enf;
        int lat;

        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy && !done && !no_fit && pll_word == 0, "R9", "reset outputs",
              {busy, done, no_fit}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk against the scan model (R1, R2, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i][63:32], VEC[i][31:0], w, nf, lat);
            model(longint'(VEC[i][63:32]), longint'(VEC[i][31:0]), ew, enf);
            check(w == ew && nf == enf, "R1/R2", $sformatf("vector %0d word", i), w, ew);
        end

        // R5/R6: hand result, exact at mul=255 div1=1 div2=7, filter 1
        run(32'd25000000, 32'd25000000, w, nf, lat);
        check(w == 32'h01FF0107 && !nf, "R5", "packed exact word", w, 32'h01FF0107);

        // R6: 200 MHz reference with div1=1 gives F=100 -> code 5
        run(32'd200000000, 32'd781250, w, nf, lat);
        check(w == 32'h05000107, "R6", "filter code 5", w, 32'h05000107);

        // R3: first candidate exact -> done in second cycle
        run(32'd25600000, 32'd100000, w, nf, lat);
        check(lat == 2, "R3", "early exit latency", lat, 2);
        check(w == 32'h01000107, "R3", "early exit word", w, 32'h01000107);

        // R4 + R10: nothing fits, full scan
        run(32'd25000000, 32'd1000, w, nf, lat);
        check(nf && w == 0, "R4", "no fit flag", {nf, w}, 33'h100000000);
        check(lat == 4097, "R10", "full scan latency", lat, 4097);

        // R7: single pulse, outputs held, busy falls
        @(negedge clk);
        check(!done && !busy, "R7", "done single cycle", {done, busy}, 0);
        repeat (5) @(negedge clk);
        check(pll_word == 0 && no_fit, "R7", "result held", pll_word, 0);

        // R8: second start during a running search is ignored
        @(negedge clk);
        parent_hz = 32'd25000000; target_hz = 32'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        parent_hz = 32'd25000000; target_hz = 32'd25000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 6;
        while (!done && lat < 10000) begin
            @(negedge clk);
            lat++;
        end
        check(no_fit && lat == 4097, "R8", "busy start ignored", lat, 4097);
        @(negedge clk);
        check(!done && !busy, "R8", "no second search", {done, busy}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule